// File: doc/BRIEF.md
# Dual-Clock Transmit Cell FIFO

This block is a 32-bit cell buffer placed between a cell generator and a physical-layer transmitter. Its write port is clocked by the generator's clock and its read port by the line-side clock. The two clocks are unrelated. Storage is counted in whole cells. A cell is 52 octets, which is 13 words of 32 bits. The header error check octet is not stored here; the physical layer adds it.

The write side keeps the buffer topped up. At each cell boundary it checks whether the buffer has room for a complete cell. If a generator cell is pending and rate control is not holding it back, that cell is pulled in, one word per clock. Otherwise the write side generates an idle cell itself. Because of this, the line side always has cells to send.

On the read side, the line clock pops words one at a time. It sees a flag on the first word of every cell and a flag that says a complete cell is ready. Read and write pointers cross between the clock domains in Gray code.

Top module: `tx_cell_fifo`

## Requirements
- R1: While reset is applied and in the first read-clock cycle after it, `rd_empty` is 1, `rd_cell_avail` is 0 and `gen_take` is 0.
- R2: A cell is begun only when, in the write domain's view, at least 13 of the 128 words are free. At most nine cells are held and no word is ever overwritten. A generator cell that arrives while the buffer is full waits, with `gen_take` low, until a cell has been read out.
- R3: At a cell boundary where `gen_avail` is 1 and `rate_hold` is 0, the generator cell is taken. `gen_take` is high for 13 consecutive write clocks, and `gen_word` is stored at each rising edge while `gen_take` is high.
- R4: At a cell boundary where `gen_avail` is 0 or `rate_hold` is 1, an idle cell is stored and `gen_take` stays low. The idle cell is the header word 0x00000001 followed by twelve words of 0x6A6A6A6A.
- R5: Once a cell is begun, all 13 of its words are written on consecutive clocks, whatever `rate_hold` does meanwhile.
- R6: Words leave the read port in the order they were written, across independent clocks.
- R7: `rd_sop` is 1 exactly when the buffer is not empty and `rd_data` holds the first word of a cell.
- R8: `rd_cell_avail` is 1 when at least 13 words are visible to the read side, and it is never 1 while `rd_empty` is 1.
- R9: `rd_pop` while `rd_empty` is 1 has no effect; the read position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (generator) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| gen_avail | input | 1 | A complete generator cell is ready to be pulled |
| gen_word | input | 32 | Current word of the pending generator cell |
| rate_hold | input | 1 | Rate control asks for a gap instead of a data cell |
| gen_take | output | 1 | `gen_word` is stored at this rising edge; generator advances |
| rclk | input | 1 | Read-side (line) clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_pop | input | 1 | Consume the word on `rd_data` at this rising edge |
| rd_data | output | 32 | Word at the head of the buffer |
| rd_sop | output | 1 | `rd_data` is the first word of a cell |
| rd_empty | output | 1 | No word is visible to the read side |
| rd_cell_avail | output | 1 | At least one full cell is visible to the read side |

## Verification
The hardest state to reach is a completely full buffer with a generator cell pending. The write side fills any free space with idle cells, so the buffer only becomes full if the line side stops reading. The bench therefore stalls the reader until nine idle cells are stored. It then offers a data cell and confirms that the cell is not taken. After reading resumes, the bench confirms that this data cell comes out as the tenth cell. A pop while empty is equally hard to reach, because the buffer refills at once. The bench issues that pop in the first read cycle after reset, before any written word has crossed the synchronizers.

// File: rtl/txcf_pkg.sv
package txcf_pkg;

    // Defaults for the block's geometry
    localparam int unsigned DATA_W_DEF     = 32;
    localparam int unsigned DEPTH_DEF      = 128;
    localparam int unsigned CELL_WORDS_DEF = 13;

    // Widest pointer the helper functions handle
    localparam int unsigned PTR_MAX = 16;
    typedef logic [PTR_MAX-1:0] ptr_t;

    // Filler octet of the idle cell payload
    localparam logic [7:0] IDLE_OCTET = 8'h6A;

    // Writer sequencing
    typedef enum logic [1:0] {
        WS_PICK = 2'd0,
        WS_DATA = 2'd1,
        WS_IDLE = 2'd2
    } wr_state_e;

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/txcf_sync.sv
module txcf_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/txcf_ram.sv
module txcf_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/txcf_writer.sv
module txcf_writer
    import txcf_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned DEPTH      = 128,
    parameter int unsigned CELL_WORDS = 13,
    parameter int unsigned PTR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_avail,
    input  logic              rate_hold,
    input  logic [DATA_W-1:0] gen_word,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic              gen_take,
    output logic              mem_we,
    output logic [PTR_W-2:0]  mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [PTR_W-1:0]  wgray
);
    localparam int unsigned CNT_W = $clog2(CELL_WORDS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_WORDS - 1);
    localparam logic [DATA_W-1:0] IDLE_HEAD = DATA_W'(1);
    localparam logic [DATA_W-1:0] IDLE_FILL = {(DATA_W/8){IDLE_OCTET}};

    wr_state_e          state_q;
    logic [CNT_W-1:0]   idx_q;
    logic [PTR_W-1:0]   wbin_q;
    logic [PTR_W-1:0]   wbin_nxt;
    logic [PTR_W-1:0]   rbin_s;
    logic [PTR_W-1:0]   used;
    logic               room;

    // Occupancy as seen from the write domain (stale read pointer is conservative)
    assign rbin_s   = PTR_W'(gray2bin(ptr_t'(rgray_s)));
    assign used     = wbin_q - rbin_s;
    assign room     = (PTR_W'(DEPTH) - used) >= PTR_W'(CELL_WORDS);
    assign wbin_nxt = wbin_q + PTR_W'(1);

    assign gen_take = (state_q == WS_DATA);
    assign mem_we   = (state_q != WS_PICK);
    assign mem_addr = wbin_q[PTR_W-2:0];

    always_comb begin
        unique case (state_q)
            WS_DATA: mem_data = gen_word;
            WS_IDLE: mem_data = (idx_q == '0) ? IDLE_HEAD : IDLE_FILL;
            default: mem_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_PICK;
            idx_q   <= '0;
            wbin_q  <= '0;
            wgray   <= '0;
        end else begin
            unique case (state_q)
                WS_PICK: begin
                    idx_q <= '0;
                    if (room) begin
                        state_q <= (gen_avail && !rate_hold) ? WS_DATA : WS_IDLE;
                    end
                end
                default: begin
                    wbin_q <= wbin_nxt;
                    wgray  <= PTR_W'(bin2gray(ptr_t'(wbin_nxt)));
                    idx_q  <= idx_q + CNT_W'(1);
                    if (idx_q == LAST_IDX) begin
                        state_q <= WS_PICK;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/txcf_reader.sv
module txcf_reader
    import txcf_pkg::*;
#(
    parameter int unsigned CELL_WORDS = 13,
    parameter int unsigned PTR_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic [PTR_W-1:0] wgray_s,
    output logic [PTR_W-2:0] rd_addr,
    output logic [PTR_W-1:0] rgray,
    output logic             empty,
    output logic             cell_avail,
    output logic             sop
);
    localparam int unsigned CNT_W = $clog2(CELL_WORDS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_WORDS - 1);

    logic [PTR_W-1:0] rbin_q;
    logic [PTR_W-1:0] rbin_nxt;
    logic [PTR_W-1:0] wbin_s;
    logic [PTR_W-1:0] level;
    logic [CNT_W-1:0] idx_q;
    logic             take;

    assign wbin_s     = PTR_W'(gray2bin(ptr_t'(wgray_s)));
    assign level      = wbin_s - rbin_q;
    assign empty      = (rgray == wgray_s);
    assign cell_avail = level >= PTR_W'(CELL_WORDS);
    assign sop        = !empty && (idx_q == '0);
    assign take       = pop && !empty;
    assign rbin_nxt   = rbin_q + PTR_W'(1);
    assign rd_addr    = rbin_q[PTR_W-2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q <= '0;
            rgray  <= '0;
            idx_q  <= '0;
        end else if (take) begin
            rbin_q <= rbin_nxt;
            rgray  <= PTR_W'(bin2gray(ptr_t'(rbin_nxt)));
            idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tx_cell_fifo.sv
module tx_cell_fifo
    import txcf_pkg::*;
#(
    parameter int unsigned DATA_W     = DATA_W_DEF,
    parameter int unsigned DEPTH      = DEPTH_DEF,
    parameter int unsigned CELL_WORDS = CELL_WORDS_DEF,
    localparam int unsigned ADDR_W    = $clog2(DEPTH),
    localparam int unsigned PTR_W     = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              gen_avail,
    input  logic [DATA_W-1:0] gen_word,
    input  logic              rate_hold,
    output logic              gen_take,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_empty,
    output logic              rd_cell_avail
);
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  rgray_w;
    logic [PTR_W-1:0]  wgray_r;

    txcf_writer #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CELL_WORDS(CELL_WORDS), .PTR_W(PTR_W)
    ) u_wr (
        .clk(wclk), .rst(wrst),
        .gen_avail(gen_avail), .rate_hold(rate_hold), .gen_word(gen_word),
        .rgray_s(rgray_w), .gen_take(gen_take),
        .mem_we(mem_we), .mem_addr(mem_waddr), .mem_data(mem_wdata),
        .wgray(wgray)
    );

    txcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(rd_data)
    );

    txcf_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );

    txcf_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );

    txcf_reader #(.CELL_WORDS(CELL_WORDS), .PTR_W(PTR_W)) u_rd (
        .clk(rclk), .rst(rrst), .pop(rd_pop), .wgray_s(wgray_r),
        .rd_addr(mem_raddr), .rgray(rgray),
        .empty(rd_empty), .cell_avail(rd_cell_avail), .sop(rd_sop)
    );
endmodule

// File: rtl/txcf_chk.sv
module txcf_chk
    import txcf_pkg::*;
#(
    parameter int unsigned DEPTH      = 128,
    parameter int unsigned CELL_WORDS = 13,
    parameter int unsigned PTR_W      = 8
) (
    input logic             wclk,
    input logic             wrst,
    input logic             rclk,
    input logic             rrst,
    input logic             gen_avail,
    input logic             rate_hold,
    input logic             gen_take,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray_w,
    input logic [PTR_W-1:0] rgray,
    input logic             rd_pop,
    input logic             rd_empty,
    input logic             rd_sop,
    input logic             rd_cell_avail
);
    logic [PTR_W-1:0] lvl_w;
    logic [7:0]       take_run;

    assign lvl_w = PTR_W'(gray2bin(ptr_t'(wgray))) - PTR_W'(gray2bin(ptr_t'(rgray_w)));

    always_ff @(posedge wclk) begin
        if (wrst)          take_run <= '0;
        else if (gen_take) take_run <= take_run + 8'd1;
        else               take_run <= '0;
    end

    // R2
    no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
        lvl_w <= PTR_W'(DEPTH));

    // R3
    take_start_chk: assert property (@(posedge wclk) disable iff (wrst)
        $rose(gen_take) |-> $past(gen_avail && !rate_hold));

    // R5
    cell_len_chk: assert property (@(posedge wclk) disable iff (wrst)
        $fell(gen_take) |-> take_run == 8'(CELL_WORDS));

    // R5
    run_bound_chk: assert property (@(posedge wclk) disable iff (wrst)
        gen_take |-> take_run < 8'(CELL_WORDS));

    // R6
    wgray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6
    rgray_step_chk: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R7
    sop_nonempty_chk: assert property (@(posedge rclk) disable iff (rrst)
        rd_sop |-> !rd_empty);

    // R8
    avail_nonempty_chk: assert property (@(posedge rclk) disable iff (rrst)
        rd_cell_avail |-> !rd_empty);

    // R9
    empty_pop_chk: assert property (@(posedge rclk) disable iff (rrst)
        (rd_pop && rd_empty) |=> $stable(rgray));
endmodule

bind tx_cell_fifo txcf_chk #(
    .DEPTH(DEPTH), .CELL_WORDS(CELL_WORDS), .PTR_W(PTR_W)
) u_chk (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
    .gen_avail(gen_avail), .rate_hold(rate_hold), .gen_take(gen_take),
    .wgray(wgray), .rgray_w(rgray_w), .rgray(rgray),
    .rd_pop(rd_pop), .rd_empty(rd_empty), .rd_sop(rd_sop),
    .rd_cell_avail(rd_cell_avail)
);

// File: tb/tb_tx_cell_fifo.sv
module tb_tx_cell_fifo;
    localparam int CW   = 13;
    localparam int MAXC = 16;
    localparam logic [31:0] IDLE_HEAD = 32'h0000_0001;
    localparam logic [31:0] IDLE_FILL = 32'h6A6A_6A6A;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic wrst = 1'b1;
    logic rrst = 1'b1;
    always #4 wclk = ~wclk;   // 125 MHz
    always #5 rclk = ~rclk;

    logic        gen_avail, gen_take, rate_hold;
    logic [31:0] gen_word, rd_data;
    logic        rd_pop, rd_sop, rd_empty, rd_cell_avail;
    logic        mon_pop  = 1'b0;
    logic        poke_pop = 1'b0;
    assign rd_pop = mon_pop | poke_pop;

    tx_cell_fifo dut (
        .wclk(wclk), .wrst(wrst), .gen_avail(gen_avail), .gen_word(gen_word),
        .rate_hold(rate_hold), .gen_take(gen_take),
        .rclk(rclk), .rrst(rrst), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_empty(rd_empty), .rd_cell_avail(rd_cell_avail)
    );

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Generator model: array of pending cells, pulled word by word
    logic [31:0] gcell [MAXC][CW];
    int g_tail = 0;
    int g_head = 0;
    int g_idx  = 0;
    int take_cycles = 0;
    assign gen_avail = (g_head < g_tail);
    assign gen_word  = gcell[g_head][g_idx];

    always @(posedge wclk) begin
        if (gen_take) begin
            take_cycles++;
            if (g_idx == CW - 1) begin
                g_idx  <= 0;
                g_head <= g_head + 1;
            end else begin
                g_idx <= g_idx + 1;
            end
        end
    end

    // Scoreboard queue of expected data-cell words
    logic [31:0] exp_q [$];

    task automatic push_cell(input int n);
        logic [31:0] w;
        @(negedge wclk);
        for (int k = 0; k < CW; k++) begin
            if (k == 0) w = 32'hA000_0000 | (32'(n) << 8);
            else        w = {8'(n), 8'(k), ~8'(n), ~8'(k)};
            gcell[g_tail][k] = w;
            exp_q.push_back(w);
        end
        g_tail = g_tail + 1;
    endtask

    // Monitor: pops words, assembles cells, compares
    bit          rd_go = 0;
    logic [31:0] cur [CW];
    int widx        = 0;
    int cells_seen  = 0;
    int idle_before = 0;
    bit data_seen   = 0;

    always @(negedge rclk) begin
        if (rd_go && !rd_empty && !rrst) begin
            check(rd_sop == (widx == 0), "R7 sop flag", 32'(rd_sop), 32'(widx == 0));
            if (cells_seen == 0 && widx == 0)
                check(rd_data == IDLE_HEAD, "R9 empty pop ignored", rd_data, IDLE_HEAD);
            cur[widx] = rd_data;
            widx++;
            mon_pop = 1'b1;
            if (widx == CW) begin
                bit bad;
                widx = 0;
                cells_seen++;
                bad = 0;
                if (cur[0] == IDLE_HEAD) begin
                    for (int k = 1; k < CW; k++) if (cur[k] != IDLE_FILL) bad = 1;
                    check(!bad, "R4 idle cell content", cur[1], IDLE_FILL);
                    if (!data_seen) idle_before++;
                end else if (exp_q.size() < CW) begin
                    check(0, "R6 unexpected data cell", cur[0], IDLE_HEAD);
                end else begin
                    logic [31:0] e0;
                    if (!data_seen) begin
                        data_seen = 1;
                        check(idle_before == 9, "R2 nine cells before data",
                              32'(idle_before), 32'd9);
                    end
                    e0 = exp_q[0];
                    for (int k = 0; k < CW; k++) begin
                        if (cur[k] != exp_q.pop_front()) bad = 1;
                    end
                    check(!bad, "R3 R6 data cell order", cur[0], e0);
                end
            end
        end else begin
            mon_pop = 1'b0;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge wclk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        int t0;
        int c0;
        rate_hold = 1'b0;
        repeat (4) @(posedge wclk);
        @(negedge wclk) wrst = 1'b0;
        @(negedge rclk) rrst = 1'b0;
        // R1: reset state, and R9: pop while empty
        check(rd_empty == 1'b1, "R1 empty after reset", 32'(rd_empty), 32'd1);
        check(rd_cell_avail == 1'b0, "R1 no cell after reset", 32'(rd_cell_avail), 32'd0);
        check(gen_take == 1'b0, "R1 no take after reset", 32'(gen_take), 32'd0);
        poke_pop = 1'b1;
        @(negedge rclk) poke_pop = 1'b0;

        // R2: stall reader until full, then offer a data cell
        repeat (250) @(negedge wclk);
        check(rd_cell_avail == 1'b1, "R8 full cell visible", 32'(rd_cell_avail), 32'd1);
        push_cell(1);
        repeat (150) @(negedge wclk);
        check(take_cycles == 0, "R2 no room no take", 32'(take_cycles), 32'd0);

        rd_go = 1;
        drain();
        check(take_cycles == CW, "R3 one cell taken", 32'(take_cycles), 32'(CW));

        for (int n = 2; n <= 7; n++) push_cell(n);
        drain();
        check(take_cycles == 7 * CW, "R3 seven cells taken", 32'(take_cycles), 32'(7 * CW));

        // R4: hold keeps data back, idle cells keep flowing
        @(negedge wclk) rate_hold = 1'b1;
        repeat (20) @(negedge wclk);
        t0 = take_cycles;
        c0 = cells_seen;
        for (int n = 8; n <= 10; n++) push_cell(n);
        repeat (400) @(negedge wclk);
        check(take_cycles == t0, "R4 hold blocks take", 32'(take_cycles), 32'(t0));
        check(cells_seen > c0 + 3, "R4 idle cells during hold", 32'(cells_seen), 32'(c0 + 4));
        @(negedge wclk) rate_hold = 1'b0;
        drain();

        // R5: hold raised mid-cell does not cut the cell
        push_cell(11);
        while (!gen_take) @(negedge wclk);
        repeat (3) @(negedge wclk);
        rate_hold = 1'b1;
        repeat (4) @(negedge wclk);
        check(gen_take == 1'b1, "R5 cell continues under hold", 32'(gen_take), 32'd1);
        rate_hold = 1'b0;
        drain();
        check(take_cycles == 11 * CW, "R5 full cell count", 32'(take_cycles), 32'(11 * CW));

        repeat (20) @(negedge wclk);
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end
endmodule